// File: doc/BRIEF.md
# General-Purpose Pin Bank with Atomic Set/Clear

This block owns a bank of general-purpose pins. Every pin is either an input or an output, as chosen by a direction register. Software drives outputs in two ways. It can write a whole output word at once. It can also write set and clear masks that change only the selected pins. The mask writes let several agents share the bank without a read-modify-write sequence. The output word can be read back to see what is being driven. An input word can be read to see the synchronized pin levels.

Each pin feeds an edge detector. The detector can be armed for rising edges, falling edges, or both. A detected edge produces a one-cycle event pulse toward a DMA engine. It also sets a sticky status bit. A status bit is cleared by writing a one to it. The bank interrupt is the OR of all status bits whose enable is set.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, pin_out, pin_oe, irq and dma_evt are all zero, and every readable register reads zero.
- R2: A write to address 0 (direction, 1 = output) appears on pin_oe on the next cycle and reads back unchanged.
- R3: A write to address 2 (set mask) drives every pin whose bit is one high on the next cycle. Pins whose bit is zero keep their value.
- R4: A write to address 3 (clear mask) drives every pin whose bit is one low on the next cycle. Pins whose bit is zero keep their value. If a set and a clear of the same bit are applied together, the clear wins.
- R5: A write to address 1 (output word) replaces all outputs on the next cycle. Reading address 1 returns the present drive state. Reading address 2 or 3 returns zero.
- R6: Reading address 4 returns the pin levels after a two-flop synchronizer. A level that is stable for two clock edges before the read edge is returned.
- R7: With bit p set in address 5 (rising enable) or address 6 (falling enable), an edge of that kind on pin p raises dma_evt[p] for exactly one cycle. The pulse appears on the third rising clock edge after the pin changes. With both enables set, both kinds of edge produce a pulse. With neither enable set, no pulse is produced.
- R8: A detected edge sets bit p of address 7 (status). The bit stays set until a write to address 7 with bit p one clears it. Zero bits in that write leave status unchanged. An edge and a clear in the same cycle leave the bit set.
- R9: irq is the registered OR of the status bits masked by address 8 (interrupt enable). It follows the status by one cycle.
- R10: Read data appears on bus_rdata at the clock edge where bus_re is sampled, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | NPIN | Write data, one bit per pin |
| bus_rdata | output | NPIN | Registered read data |
| pin_in | input | NPIN | Raw pin levels, asynchronous |
| pin_out | output | NPIN | Output drive values |
| pin_oe | output | NPIN | Output enables (1 = drive) |
| irq | output | 1 | Bank interrupt |
| dma_evt | output | NPIN | One-cycle edge event per pin |

## Verification
A wrong output word shows on pin_out one cycle after the write that caused it. This includes a mask that leaks into unselected pins or a set that beats a clear. A bad sticky status bit shows on irq one cycle after it changes. A bad status bit also shows in the status readback on the next read. A fault in the synchronizer or in the edge detector moves or drops the dma_evt pulse. That pulse is expected exactly three edges after the pin changes, so a wrong stage count or a wrong edge polarity is seen within four cycles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_DIR  = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SET  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_IN   = 4'd4;
  localparam logic [ADDR_W-1:0] A_RISE = 4'd5;
  localparam logic [ADDR_W-1:0] A_FALL = 4'd6;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd8;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_out.sv
module gpio_out #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_all,
  input  logic [NPIN-1:0] wdata,
  input  logic [NPIN-1:0] set_mask,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] out_q
);
  // clear is applied after set so a coincident clear dominates
  always_ff @(posedge clk) begin
    if (rst)         out_q <= '0;
    else if (wr_all) out_q <= wdata;
    else             out_q <= (out_q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] w1c,
  output logic [NPIN-1:0] evt_q,
  output logic [NPIN-1:0] stat_q
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NPIN; g++) begin : g_pin
      always_comb
        hit[g] = (rise_en[g] & lvl[g] & ~prev_q[g]) |
                 (fall_en[g] & ~lvl[g] & prev_q[g]);

      always_ff @(posedge clk) begin
        if (rst) begin
          prev_q[g] <= 1'b0;
          evt_q[g]  <= 1'b0;
          stat_q[g] <= 1'b0;
        end else begin
          prev_q[g] <= lvl[g];
          evt_q[g]  <= hit[g];
          stat_q[g] <= (stat_q[g] & ~w1c[g]) | hit[g];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NPIN        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic              irq,
  output logic [NPIN-1:0]   dma_evt
);
  logic [NPIN-1:0] dir_q, rise_en_q, fall_en_q, irq_en_q;
  logic [NPIN-1:0] lvl, stat, out_q, rd_mux;
  logic [NPIN-1:0] set_m, clr_m, w1c_m;
  logic            wr_out;

  assign wr_out = bus_we && (bus_addr == A_OUT);
  assign set_m  = (bus_we && bus_addr == A_SET)  ? bus_wdata : '0;
  assign clr_m  = (bus_we && bus_addr == A_CLR)  ? bus_wdata : '0;
  assign w1c_m  = (bus_we && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      irq_en_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DIR:   dir_q     <= bus_wdata;
        A_RISE:  rise_en_q <= bus_wdata;
        A_FALL:  fall_en_q <= bus_wdata;
        A_IEN:   irq_en_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(lvl)
  );

  gpio_out #(.NPIN(NPIN)) u_out (
    .clk(clk), .rst(rst), .wr_all(wr_out), .wdata(bus_wdata),
    .set_mask(set_m), .clr_mask(clr_m), .out_q(out_q)
  );

  gpio_edge #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .rise_en(rise_en_q),
    .fall_en(fall_en_q), .w1c(w1c_m), .evt_q(dma_evt), .stat_q(stat)
  );

  always_comb begin
    case (bus_addr)
      A_DIR:   rd_mux = dir_q;
      A_OUT:   rd_mux = out_q;
      A_IN:    rd_mux = lvl;
      A_RISE:  rd_mux = rise_en_q;
      A_FALL:  rd_mux = fall_en_q;
      A_STAT:  rd_mux = stat;
      A_IEN:   rd_mux = irq_en_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_mux;
      irq <= |(stat & irq_en_q);
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   pin_out,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq,
  input logic [NPIN-1:0]   dma_evt,
  input logic [NPIN-1:0]   rise_en,
  input logic [NPIN-1:0]   fall_en,
  input logic [NPIN-1:0]   stat,
  input logic [NPIN-1:0]   irq_en
);
  logic [NPIN-1:0] clr_req;
  assign clr_req = (bus_we && bus_addr == A_STAT) ? bus_wdata : '0;

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata));

  p_set_high_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SET) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  p_clr_low_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_CLR) |=>
      ((pin_out & $past(bus_wdata)) == '0) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  p_evt_armed_r7: assert property (@(posedge clk) disable iff (rst)
    (dma_evt & ~($past(rise_en) | $past(fall_en))) == '0);

  p_stat_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(stat) & ~stat & ~$past(clr_req)) == '0);

  p_evt_sets_stat_r8: assert property (@(posedge clk) disable iff (rst)
    (dma_evt & ~stat) == '0);

  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    irq == (|($past(stat) & $past(irq_en))));
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .dma_evt(dma_evt), .rise_en(rise_en_q), .fall_en(fall_en_q),
  .stat(stat), .irq_en(irq_en_q)
);

// File: tb/test_gpio_bank.sv
module test_gpio_bank;
  localparam int NPIN = 8;
  localparam int TIMEOUT_CYC = 200000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_we = 1'b0;
  logic            bus_re = 1'b0;
  logic [3:0]      bus_addr = '0;
  logic [NPIN-1:0] bus_wdata = '0;
  logic [NPIN-1:0] bus_rdata;
  logic [NPIN-1:0] pin_in = '0;
  logic [NPIN-1:0] pin_out, pin_oe, dma_evt;
  logic            irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_bank #(.NPIN(NPIN)) i_gpio_bank (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
    .dma_evt(dma_evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [NPIN-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [NPIN-1:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * TIMEOUT_CYC);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NPIN-1:0] r, model;
    tick(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 dma_evt", dma_evt, 0);
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), r);
      chk("R1 reg readback", r, 0);
    end

    // R2 direction sweep
    for (int v = 0; v < 256; v += 17) begin
      wr(4'd0, 8'(v));
      chk("R2 pin_oe", pin_oe, v);
      rd(4'd0, r);
      chk("R2 dir readback", r, v);
    end

    // R5 full output word sweep, R10 read timing
    for (int v = 0; v < 256; v++) begin
      wr(4'd1, 8'(v));
      chk("R5 pin_out", pin_out, v);
      rd(4'd1, r);
      chk("R5 out readback R10", r, v);
    end
    rd(4'd2, r); chk("R5 set reads zero", r, 0);
    rd(4'd3, r); chk("R5 clr reads zero", r, 0);

    // R3 / R4 set and clear masks
    wr(4'd1, 8'h00);
    model = '0;
    for (int k = 0; k < 64; k++) begin
      logic [NPIN-1:0] s, c;
      s = 8'((k * 29 + 3) & 255);
      c = 8'((k * 53 + 7) & 255);
      wr(4'd2, s); model = model | s;
      chk("R3 set mask", pin_out, model);
      wr(4'd3, c); model = model & ~c;
      chk("R4 clear mask", pin_out, model);
    end
    wr(4'd2, 8'h00);
    chk("R3 zero set mask", pin_out, model);
    wr(4'd3, 8'h00);
    chk("R4 zero clear mask", pin_out, model);

    // R6 synchronized input readback
    for (int v = 1; v < 256; v += 37) begin
      pin_in = 8'(v);
      tick(2);
      rd(4'd4, r);
      chk("R6 input level", r, v);
    end
    pin_in = '0;
    tick(4);

    // R7 / R8 / R9 edge modes per pin
    wr(4'd8, 8'hFF);
    for (int p = 0; p < NPIN; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [NPIN-1:0] bit_p, exp_stat;
        bit_p = 8'(1 << p);
        wr(4'd5, m[0] ? bit_p : 8'h00);
        wr(4'd6, m[1] ? bit_p : 8'h00);
        wr(4'd7, 8'hFF);
        tick(1);
        pin_in = bit_p;
        tick(3);
        chk("R7 rise pulse", dma_evt, m[0] ? bit_p : 8'h00);
        tick(1);
        chk("R7 pulse one cycle", dma_evt, 0);
        chk("R9 irq after rise", irq, m[0]);
        pin_in = 8'h00;
        tick(3);
        chk("R7 fall pulse", dma_evt, m[1] ? bit_p : 8'h00);
        tick(1);
        chk("R7 fall one cycle", dma_evt, 0);
        chk("R9 irq sticky", irq, (m != 0));
        exp_stat = (m != 0) ? bit_p : 8'h00;
        rd(4'd7, r); chk("R8 status set", r, exp_stat);
        wr(4'd7, ~bit_p);
        rd(4'd7, r); chk("R8 zero bits keep status", r, exp_stat);
        wr(4'd7, bit_p);
        rd(4'd7, r); chk("R8 w1c clears", r, 0);
        chk("R9 irq drops", irq, 0);
      end
    end

    // R9 enable masks irq
    wr(4'd5, 8'hFF); wr(4'd6, 8'h00); wr(4'd8, 8'h00);
    pin_in = 8'h0F;
    tick(5);
    chk("R9 masked irq", irq, 0);
    wr(4'd8, 8'h08);
    tick(1);
    chk("R9 enabled irq", irq, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule